// File: doc/BRIEF.md
# Two-Bank Edge and Level Interrupt Controller

This block gathers 64 interrupt lines and drives one request to a processor. The lines are split into a lower group (sources 0 to 31) and an upper group (sources 32 to 63). Software reaches each group through a small word-wide register bus. Per group, it can read latched edge events, set per-source enables, clear events by writing ones to an acknowledge word, and read the synchronized live state of every line.

A fixed set of positions in the lower group is level-type. Those sources are never latched. They request service for as long as their synchronized line is high. All other sources are edge-type. Every line passes through a two-flop synchronizer and a rising-edge detector. A rising edge is recorded only if the source is enabled at that moment. As a result, enabling a source whose line is already high does not create an event.

The block also provides the number of the highest-numbered pending source and a valid flag, so a handler can select a source without scanning the words itself.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Byte address 0x20 is the base of the lower group and 0x10 is the base of the upper group. From the base, the event word is at +0x0, the enable word at +0x4, the acknowledge word at +0x8 and the live-level word at +0xC. Bit n of a word belongs to source base_index+n. Any other address, including one with address bits [1:0] not zero, reads as 0 and ignores writes.
- R2: While reset is held and right after it, every event and enable bit is 0, and cpu_irq and win_valid are low.
- R3: An edge-type source whose enable bit is 1 sets its event bit when its line rises. The bit can be read on the third rising clock edge after the line changes. A rise while the enable bit is 0 is never recorded.
- R4: Writing the acknowledge word clears each event bit written as 1 and leaves every bit written as 0 unchanged. Reading the acknowledge word returns 0.
- R5: Setting an enable bit while that source's line is already high neither sets its event bit nor raises cpu_irq.
- R6: Lower-group sources 20 to 29 are level-type. With parameter LVL_ALT=1 the range is 20 to 28 instead. Upper-group sources are all edge-type. A level-type source never sets its event bit and is pending while its synchronized line is high. The live-level word returns the synchronized state of all 32 lines of its group.
- R7: A source is pending when (event OR (line AND level-type)) AND enable. cpu_irq is high exactly when some source is pending.
- R8: win_id is the highest-numbered pending source, so the upper group is served before the lower group. win_valid is high when any source is pending. win_id is 0 when nothing is pending.
- R9: Reading an enable word returns exactly the value last written to it.
- R10: If a rising edge and an acknowledge of the same source fall in the same cycle, the event bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 64 | Interrupt lines, bit n is source n |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cpu_irq | output | 1 | Request to the processor |
| win_valid | output | 1 | A pending source exists |
| win_id | output | 6 | Highest-numbered pending source |

## Verification
Two functions can act on the same source in the same cycle: edge capture and acknowledge clearing. To provoke this, the bench raises a line whose event is already latched, then times an acknowledge write so that it lands on the clock edge where the synchronized rise is recorded. The event word read afterwards must still show the bit. A cycle-accurate behavioural model runs in parallel and is compared on every clock: request, winner and read data at whatever address is on the bus. This comparison covers overlaps between enable writes and edges that the directed steps do not hit.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  localparam int SRC_W     = 32;
  localparam int NBANK     = 2;
  localparam int TOTAL_SRC = SRC_W * NBANK;
  localparam int IDX_W     = $clog2(TOTAL_SRC);
  localparam int ADDR_W    = 6;

  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } reg_sel_e;

  // byte base of a bank inside the 0x40 window
  function automatic logic [ADDR_W-1:0] bank_base(input int b);
    return (b == 0) ? 6'h20 : 6'h10;
  endfunction

  // level-type source positions of a bank
  function automatic logic [SRC_W-1:0] level_mask_of(input int b, input bit alt);
    if (b != 0) return '0;
    return alt ? 32'h1FF0_0000 : 32'h3FF0_0000;
  endfunction
endpackage

// File: rtl/intc_sync.sv
`timescale 1ns/1ps
module intc_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise
);
  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[k] <= '0;
      else        chain[k] <= chain[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= chain[STAGES-1];
  end

  assign dout = chain[STAGES-1];
  assign rise = dout & ~prev;
endmodule

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
module intc_bank
  import irq_ctrl_pkg::*;
#(
  parameter int           W     = SRC_W,
  parameter logic [W-1:0] LMASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  input  logic [W-1:0] rise_in,
  input  logic         wr,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] event_q,
  output logic [W-1:0] enable_q,
  output logic [W-1:0] level_q,
  output logic [W-1:0] pend,
  output logic [W-1:0] set_o,
  output logic [W-1:0] clr_o,
  output logic         en_wr
);
  assign en_wr = wr && (sel == REG_ENABLE);
  assign clr_o = (wr && (sel == REG_ACK)) ? wdata : '0;
  // only edge-type positions latch; old enable gates the capture
  assign set_o = rise_in & enable_q & ~LMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) event_q <= '0;
    else        event_q <= (event_q & ~clr_o) | set_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable_q <= '0;
    else if (en_wr) enable_q <= wdata;
  end

  assign level_q = lvl_in;
  assign pend    = (event_q | (lvl_in & LMASK)) & enable_q;
endmodule

// File: rtl/intc_prio.sv
`timescale 1ns/1ps
module intc_prio #(
  parameter int N   = 64,
  localparam int IDW = $clog2(N)
) (
  input  logic [N-1:0]   pend,
  output logic           valid,
  output logic [IDW-1:0] id
);
  function automatic logic [IDW-1:0] top_bit(input logic [N-1:0] v);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      if (v[i]) r = IDW'(i);
    return r;
  endfunction

  assign valid = |pend;
  assign id    = top_bit(pend);
endmodule

// File: rtl/banked_irq_ctrl.sv
`timescale 1ns/1ps
module banked_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit LVL_ALT     = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TOTAL_SRC-1:0] irq_lines,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [SRC_W-1:0]     bus_wdata,
  output logic [SRC_W-1:0]     bus_rdata,
  output logic                 cpu_irq,
  output logic                 win_valid,
  output logic [IDX_W-1:0]     win_id
);
  logic [TOTAL_SRC-1:0] line_s, line_rise, pend_all;
  logic [NBANK-1:0][SRC_W-1:0] ev, en, lv, pd, st, cl;
  logic [NBANK-1:0] hit, en_wr;
  reg_sel_e sel;

  assign sel = reg_sel_e'(bus_addr[3:2]);

  intc_sync #(.W(TOTAL_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_lines), .dout(line_s), .rise(line_rise)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BASE = bank_base(b);
    assign hit[b] = (bus_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (bus_addr[1:0] == 2'b00);

    intc_bank #(.W(SRC_W), .LMASK(level_mask_of(b, LVL_ALT))) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lvl_in(line_s[b*SRC_W +: SRC_W]),
      .rise_in(line_rise[b*SRC_W +: SRC_W]),
      .wr(bus_we && hit[b]), .sel(sel), .wdata(bus_wdata),
      .event_q(ev[b]), .enable_q(en[b]), .level_q(lv[b]),
      .pend(pd[b]), .set_o(st[b]), .clr_o(cl[b]), .en_wr(en_wr[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (hit[b]) begin
        case (sel)
          REG_EVENT:  bus_rdata = ev[b];
          REG_ENABLE: bus_rdata = en[b];
          REG_ACK:    bus_rdata = '0;
          REG_LEVEL:  bus_rdata = lv[b];
          default:    bus_rdata = '0;
        endcase
      end
    end
  end

  assign pend_all = pd;
  assign cpu_irq  = |pend_all;

  intc_prio #(.N(TOTAL_SRC)) u_prio (.pend(pend_all), .valid(win_valid), .id(win_id));

  // named internal events for the checker
  logic [SRC_W-1:0] ev_lo, ev_hi, set_lo, set_hi, clr_lo, clr_hi, en_lo, en_hi;
  logic en_wr_lo, en_wr_hi;
  assign ev_lo = ev[0];  assign ev_hi = ev[1];
  assign set_lo = st[0]; assign set_hi = st[1];
  assign clr_lo = cl[0]; assign clr_hi = cl[1];
  assign en_lo = en[0];  assign en_hi = en[1];
  assign en_wr_lo = en_wr[0];
  assign en_wr_hi = en_wr[1];
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter logic [SRC_W-1:0] LMASK_LO = 32'h3FF0_0000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_irq,
  input logic                 win_valid,
  input logic [IDX_W-1:0]     win_id,
  input logic [TOTAL_SRC-1:0] pend_all,
  input logic [SRC_W-1:0]     bus_wdata,
  input logic [SRC_W-1:0]     ev_lo,
  input logic [SRC_W-1:0]     ev_hi,
  input logic [SRC_W-1:0]     set_lo,
  input logic [SRC_W-1:0]     set_hi,
  input logic [SRC_W-1:0]     clr_lo,
  input logic [SRC_W-1:0]     clr_hi,
  input logic [SRC_W-1:0]     en_lo,
  input logic [SRC_W-1:0]     en_hi,
  input logic                 en_wr_lo,
  input logic                 en_wr_hi
);
  // R7
  irq_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) cpu_irq == win_valid);
  // R8
  win_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ((pend_all >> win_id) == {{(TOTAL_SRC-1){1'b0}}, 1'b1}));
  // R4
  ack_clear_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_lo & $past(clr_lo & ~set_lo)) == '0));
  // R4
  ack_clear_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_hi & $past(clr_hi & ~set_hi)) == '0));
  // R10
  set_keep_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_lo & $past(set_lo)) == $past(set_lo)));
  // R10
  set_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_hi & $past(set_hi)) == $past(set_hi)));
  // R5
  new_event_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_lo & ~$past(ev_lo) & ~$past(set_lo)) == '0));
  // R3
  new_event_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_hi & ~$past(ev_hi) & ~$past(set_hi)) == '0));
  // R6
  lvl_noevent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lo & LMASK_LO) == '0);
  // R9
  en_echo_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_lo |=> (en_lo == $past(bus_wdata)));
  // R9
  en_echo_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_hi |=> (en_hi == $past(bus_wdata)));
endmodule

bind banked_irq_ctrl irq_ctrl_chk #(.LMASK_LO(level_mask_of(0, LVL_ALT))) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .win_valid(win_valid), .win_id(win_id),
  .pend_all(pend_all), .bus_wdata(bus_wdata),
  .ev_lo(ev_lo), .ev_hi(ev_hi), .set_lo(set_lo), .set_hi(set_hi),
  .clr_lo(clr_lo), .clr_hi(clr_hi), .en_lo(en_lo), .en_hi(en_hi),
  .en_wr_lo(en_wr_lo), .en_wr_hi(en_wr_hi)
);

// File: tb/tb_banked_irq_ctrl.sv
`timescale 1ns/1ps
module tb_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_lines = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq, win_valid;
  logic [5:0]  win_id;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  banked_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .win_valid(win_valid), .win_id(win_id)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_s1, m_s2, m_prev, m_ev, m_en;

  function automatic bit is_lvl(int i);
    return (i >= 20) && (i <= 29);
  endfunction

  function automatic logic [5:0] raddr(int bk, int r);
    return ((bk == 0) ? 6'h20 : 6'h10) + 6'(r * 4);
  endfunction

  function automatic logic [63:0] exp_pend();
    logic [63:0] p;
    for (int i = 0; i < 64; i++)
      p[i] = (m_ev[i] | (m_s2[i] & is_lvl(i))) & m_en[i];
    return p;
  endfunction

  function automatic int exp_win(logic [63:0] p);
    int w = -1;
    for (int i = 0; i < 64; i++) if (p[i]) w = i;
    return w;
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    for (int bk = 0; bk < 2; bk++) begin
      if (a == raddr(bk, 0)) return m_ev[bk*32 +: 32];
      if (a == raddr(bk, 1)) return m_en[bk*32 +: 32];
      if (a == raddr(bk, 2)) return 32'h0;
      if (a == raddr(bk, 3)) return m_s2[bk*32 +: 32];
    end
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_ev = '0; m_en = '0;
    end else begin
      logic [63:0] rise;
      rise = m_s2 & ~m_prev;
      for (int i = 0; i < 64; i++) begin
        int bk;
        int bt;
        bk = i / 32;
        bt = i % 32;
        if (bus_we && bus_addr == raddr(bk, 2) && bus_wdata[bt]) m_ev[i] = 1'b0;
        if (rise[i] && m_en[i] && !is_lvl(i)) m_ev[i] = 1'b1;
        if (bus_we && bus_addr == raddr(bk, 1)) m_en[i] = bus_wdata[bt];
      end
      m_prev = m_s2;
      m_s2 = m_s1;
      m_s1 = irq_lines;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [63:0] p;
      int w;
      p = exp_pend();
      w = exp_win(p);
      chk(cpu_irq === (p != 0), "R7 cpu_irq vs model", 64'(cpu_irq), 64'(p != 0));
      chk(win_valid === (w >= 0), "R8 win_valid vs model", 64'(win_valid), 64'(w >= 0));
      chk(win_id === ((w >= 0) ? 6'(w) : 6'd0), "R8 win_id vs model", 64'(win_id),
          64'((w >= 0) ? w : 0));
      chk(bus_rdata === m_read(bus_addr), "R1 read data vs model", 64'(bus_rdata),
          64'(m_read(bus_addr)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1 chk(bus_rdata === e, tag, 64'(bus_rdata), 64'(e));
  endtask

  task automatic out_chk(input bit v, input logic [5:0] id, input string tag);
    @(negedge clk);
    #1;
    chk(cpu_irq === v, tag, 64'(cpu_irq), 64'(v));
    chk(win_valid === v && win_id === id, tag, {57'd0, win_valid, win_id}, {57'd0, v, id});
  endtask

  task automatic setl(input int i, input bit v);
    @(negedge clk);
    irq_lines[i] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int i);
    setl(i, 1'b1);
    idle(2);
    setl(i, 1'b0);
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL R3 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R2: reset state
    idle(3);
    #1 chk(cpu_irq === 1'b0 && win_valid === 1'b0, "R2 outputs in reset",
           {cpu_irq, win_valid}, 0);
    @(negedge clk) rst_n = 1'b1;
    rd_chk(6'h24, 32'h0, "R2 lower enable after reset");
    rd_chk(6'h14, 32'h0, "R2 upper enable after reset");
    rd_chk(6'h20, 32'h0, "R2 lower event after reset");

    // R3: edge capture on an enabled lower source
    wr(6'h24, 32'h0000_0020);
    pulse(5);
    idle(2);
    rd_chk(6'h20, 32'h0000_0020, "R3 event of source 5");
    out_chk(1'b1, 6'd5, "R7 request for source 5");

    // R1/R8: upper bank source 40 wins over source 5
    wr(6'h14, 32'h0000_0100);
    pulse(40);
    idle(2);
    rd_chk(6'h10, 32'h0000_0100, "R1 upper event at 0x10");
    out_chk(1'b1, 6'd40, "R8 upper group first");

    // R4: zero bits do nothing, one bits clear, ack reads zero
    wr(6'h28, 32'hFFFF_FFDF);
    rd_chk(6'h20, 32'h0000_0020, "R4 zero ack bit keeps event");
    wr(6'h18, 32'h0000_0100);
    rd_chk(6'h10, 32'h0, "R4 ack clears source 40");
    out_chk(1'b1, 6'd5, "R8 winner after ack");
    rd_chk(6'h18, 32'h0, "R4 upper ack reads zero");
    rd_chk(6'h28, 32'h0, "R4 lower ack reads zero");

    // R3: rise while disabled is not recorded
    pulse(7);
    idle(2);
    rd_chk(6'h20, 32'h0000_0020, "R3 disabled source 7 ignored");

    // R5: enabling a line that is already high
    wr(6'h28, 32'h0000_0020);
    setl(10, 1'b1);
    idle(5);
    wr(6'h24, 32'h0000_0420);
    idle(4);
    out_chk(1'b0, 6'd0, "R5 no request after enable on high line");
    rd_chk(6'h20, 32'h0, "R5 no event after enable on high line");
    setl(10, 1'b0);
    idle(3);
    pulse(10);
    idle(2);
    rd_chk(6'h20, 32'h0000_0400, "R3 fresh edge on source 10");
    wr(6'h28, 32'h0000_0400);

    // R6: level source 22 follows its line
    wr(6'h24, 32'h0040_0420);
    setl(22, 1'b1);
    idle(3);
    out_chk(1'b1, 6'd22, "R6 level source 22 pending");
    rd_chk(6'h2C, 32'h0040_0000, "R6 live level word");
    rd_chk(6'h20, 32'h0, "R6 level source not latched");
    setl(22, 1'b0);
    idle(3);
    out_chk(1'b0, 6'd0, "R6 level request drops with line");

    // R6: upper position 20 (source 52) is edge-type
    wr(6'h14, 32'h0010_0000);
    pulse(52);
    idle(2);
    rd_chk(6'h10, 32'h0010_0000, "R6 upper source 52 latches");
    out_chk(1'b1, 6'd52, "R8 source 52 wins");
    wr(6'h18, 32'h0010_0000);
    out_chk(1'b0, 6'd0, "R4 request gone after ack of 52");

    // R9: enable echoes the written value
    wr(6'h14, 32'hA5A5_0F0F);
    rd_chk(6'h14, 32'hA5A5_0F0F, "R9 upper enable readback");
    wr(6'h14, 32'h0);
    rd_chk(6'h14, 32'h0, "R9 upper enable cleared");

    // R1: unmapped and misaligned addresses
    rd_chk(6'h04, 32'h0, "R1 unmapped 0x04 reads zero");
    rd_chk(6'h30, 32'h0, "R1 unmapped 0x30 reads zero");
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h25, 32'hFFFF_FFFF);
    rd_chk(6'h24, 32'h0040_0420, "R1 stray writes ignored");

    // R10: edge and ack on source 5 in the same cycle
    pulse(5);
    idle(2);
    rd_chk(6'h20, 32'h0000_0020, "R10 setup event 5");
    setl(5, 1'b1);
    @(negedge clk);
    wr(6'h28, 32'h0000_0020);
    rd_chk(6'h20, 32'h0000_0020, "R10 capture beats ack");
    setl(5, 1'b0);
    wr(6'h28, 32'h0000_0020);
    rd_chk(6'h20, 32'h0, "R4 later ack clears source 5");

    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule